// File: doc/BRIEF.md
# I2C Master Message Sequencer

This block sits between a transfer-level client and a bit-level I2C engine. The client hands over a transfer as a list of messages, one at a time. Each message gives a 7-bit target address, a direction, a byte count, a set of framing modifiers and a marker for the final message. The sequencer expands every message into an ordered series of bus primitives (start, stop, byte write, byte read) and issues them to the engine one at a time. It waits for the engine's response after each primitive before it issues the next. Write payload is pulled from an input byte stream. Bytes read from the target are pushed out on an output byte stream.

Consecutive messages of one transfer are joined by a repeated start. The modifiers can change this framing in five ways:
- a slave NAK can be treated as an acknowledge;
- the master acknowledge bit after read bytes can be omitted;
- the start and address phase of a message can be suppressed;
- the direction bit placed on the wire can be inverted;
- a stop can be forced after a message.

A slave NAK that is not ignored ends the transfer early with a stop. The remaining messages of that transfer are then accepted and discarded, and their write payload is consumed, so the client and the byte stream stay aligned. At the end of each transfer the block reports a single outcome: success, or failure with the index of the message that failed.

Top module: `i2c_xfer_sequencer`

## Requirements
- R1: The address phase sends one WRITE primitive whose byte is {address[6:0], dir}. dir is 1 for a read and 0 for a write, and it is inverted when modifier bit 3 (direction flip) is set. The data direction of the message itself does not change.
- R2: A final write message with no modifiers produces the sequence START, address WRITE, one WRITE for each payload byte (taken from the tx stream in arrival order), STOP. Its outcome is then reported with ok=1.
- R3: A read message issues one READ primitive per byte. The READ carries cmd_mack_o=1 for every byte except the last, which carries cmd_mack_o=0. Each response byte appears once on rx_data_o, with rx_valid_o high, one cycle after the response.
- R4: Between two messages of one transfer, with no modifiers, the sequencer issues START again with no STOP in between, followed by the new address byte.
- R5: A write response with rsp_ack_i=0 and modifier bit 0 clear causes a STOP next, with no further byte primitives. The remaining messages of the transfer are accepted without issuing primitives. The unsent payload of the failing message and of every dropped write message is consumed from the tx stream. The outcome is ok=0, and the index is the 0-based position of the failing message.
- R6: With modifier bit 0 (ignore NAK) set, a response with rsp_ack_i=0 is handled as an acknowledge, and all bytes and all following messages are sent.
- R7: With modifier bit 1 (omit master acknowledge) set, every READ of the message carries cmd_noack_o=1. Otherwise cmd_noack_o=0.
- R8: Modifier bit 2 (no start) on a message that follows another without a stop issues neither START nor an address byte. Its data primitives follow the previous message's directly.
- R9: Modifier bit 2 on a message that begins with the bus idle still issues START, but skips the address byte.
- R10: Modifier bit 4 (force stop) issues STOP after that message even if more messages follow, and the next message opens with a fresh START.
- R11: A message of length zero issues only its start and address phase, followed by whatever stop or repeated start comes next.
- R12: After reset the block is idle: msg_ready_o=1, cmd_valid_o=0, rx_valid_o=0 and done_valid_o=0.
- R13: At most one primitive is outstanding: cmd_valid_o stays low from the handshake of a primitive until its response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| msg_valid_i | input | 1 | Message descriptor valid |
| msg_ready_o | output | 1 | Sequencer accepts a descriptor |
| msg_addr_i | input | 7 | Target address |
| msg_rd_i | input | 1 | 1 = read message, 0 = write message |
| msg_len_i | input | LEN_W | Byte count of the message |
| msg_mods_i | input | 5 | Modifiers: [0] ignore NAK, [1] omit master ack, [2] no start, [3] flip direction, [4] force stop |
| msg_last_i | input | 1 | Final message of the transfer |
| tx_valid_i | input | 1 | Write payload byte valid |
| tx_ready_o | output | 1 | Payload byte taken |
| tx_data_i | input | 8 | Write payload byte |
| rx_valid_o | output | 1 | Read byte valid (single-cycle pulse) |
| rx_data_o | output | 8 | Read byte |
| cmd_valid_o | output | 1 | Primitive valid |
| cmd_ready_i | input | 1 | Engine takes the primitive |
| cmd_op_o | output | 2 | 0 START, 1 STOP, 2 WRITE, 3 READ |
| cmd_wdata_o | output | 8 | Byte for WRITE |
| cmd_mack_o | output | 1 | READ: master answers ACK (1) or NAK (0) |
| cmd_noack_o | output | 1 | READ: omit the master acknowledge bit |
| rsp_valid_i | input | 1 | Engine response for the outstanding primitive |
| rsp_ack_i | input | 1 | WRITE: slave acknowledged |
| rsp_rdata_i | input | 8 | READ: byte received |
| done_valid_o | output | 1 | Transfer outcome valid (single-cycle pulse) |
| done_ok_o | output | 1 | 1 = success, 0 = aborted by NAK |
| done_idx_o | output | IDX_W | Index of the failing message (last message index on success) |

## Verification
The point of contention is a slave NAK that arrives on the final byte of a message while more messages are queued. In that cycle the abort path (stop, then flush) and the end-of-message path (repeated start) both want the next move. The bench provokes this by letting the engine model NAK exactly the last payload byte of a non-final message: once with the ignore flag clear, expecting STOP, a flush and a failure at index 0, and once with the flag set, expecting a repeated start and success. The command trace and the count of consumed payload bytes are compared against sequences the bench builds from the requirements.

// File: rtl/i2cseq_pkg.sv
package i2cseq_pkg;

    typedef enum logic [1:0] {
        OP_START = 2'd0,
        OP_STOP  = 2'd1,
        OP_WRITE = 2'd2,
        OP_READ  = 2'd3
    } bus_op_e;

    // Packed so that ign_nak lands on bit 0 of the modifier port.
    typedef struct packed {
        logic force_stop;
        logic flip_dir;
        logic no_start;
        logic no_rd_ack;
        logic ign_nak;
    } msg_mod_t;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_START = 3'd1,
        ST_ADDR  = 3'd2,
        ST_DATA  = 3'd3,
        ST_STOP  = 3'd4,
        ST_DRAIN = 3'd5,
        ST_FLUSH = 3'd6
    } seq_st_e;

endpackage

// File: rtl/i2cseq_frame_plan.sv
module i2cseq_frame_plan #(
    parameter int ADDR_W = 7
) (
    input  logic              bus_open_i,
    input  logic              no_start_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              dir_rd_i,
    input  logic              flip_i,
    output logic              need_start_o,
    output logic [ADDR_W:0]   addr_byte_o
);
    // A start is skipped only when the bus is still held and the message
    // asks to continue without one.
    assign need_start_o = !(bus_open_i && no_start_i);
    assign addr_byte_o  = {addr_i, dir_rd_i ^ flip_i};
endmodule

// File: rtl/i2cseq_rx_out.sv
module i2cseq_rx_out #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              rx_valid_o,
    output logic [DATA_W-1:0] rx_data_o
);
    typedef struct packed {
        logic              vld;
        logic [DATA_W-1:0] dat;
    } rx_t;

    rx_t rx_d, rx_q;

    always_comb begin
        rx_d     = rx_q;
        rx_d.vld = capture_i;
        if (capture_i) rx_d.dat = data_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rx_q <= '0;
        else        rx_q <= rx_d;
    end

    assign rx_valid_o = rx_q.vld;
    assign rx_data_o  = rx_q.dat;

    p_rx_echo_r3: assert property (@(posedge clk) disable iff (!rst_n)
        capture_i |=> (rx_valid_o && rx_data_o == $past(data_i)))
        else $error("p_rx_echo_r3");
endmodule

// File: rtl/i2c_xfer_sequencer.sv
module i2c_xfer_sequencer
    import i2cseq_pkg::*;
#(
    parameter int LEN_W = 8,
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             msg_valid_i,
    output logic             msg_ready_o,
    input  logic [6:0]       msg_addr_i,
    input  logic             msg_rd_i,
    input  logic [LEN_W-1:0] msg_len_i,
    input  logic [4:0]       msg_mods_i,
    input  logic             msg_last_i,
    input  logic             tx_valid_i,
    output logic             tx_ready_o,
    input  logic [7:0]       tx_data_i,
    output logic             rx_valid_o,
    output logic [7:0]       rx_data_o,
    output logic             cmd_valid_o,
    input  logic             cmd_ready_i,
    output logic [1:0]       cmd_op_o,
    output logic [7:0]       cmd_wdata_o,
    output logic             cmd_mack_o,
    output logic             cmd_noack_o,
    input  logic             rsp_valid_i,
    input  logic             rsp_ack_i,
    input  logic [7:0]       rsp_rdata_i,
    output logic             done_valid_o,
    output logic             done_ok_o,
    output logic [IDX_W-1:0] done_idx_o
);
    localparam int ADDR_W = 7;
    localparam logic [LEN_W-1:0] LEN_ONE = LEN_W'(1);
    localparam logic [IDX_W-1:0] IDX_ONE = IDX_W'(1);

    typedef struct packed {
        seq_st_e           st;
        logic              wait_rsp;
        logic [ADDR_W-1:0] addr;
        logic              rd;
        msg_mod_t          mods;
        logic [LEN_W-1:0]  len;
        logic [LEN_W-1:0]  cnt;
        logic              last;
        logic              bus_open;
        logic              err;
        logic [IDX_W-1:0]  idx;
        logic [LEN_W-1:0]  drain;
        logic              drain_end;
        logic              done_v;
        logic              done_ok;
        logic [IDX_W-1:0]  done_idx;
    } seq_t;

    seq_t    q, d;
    bus_op_e op;
    logic    need_start;
    logic [ADDR_W:0] addr_byte;
    logic    rx_capture;

    i2cseq_frame_plan #(.ADDR_W(ADDR_W)) u_plan (
        .bus_open_i  (q.bus_open),
        .no_start_i  (msg_mods_i[2]),
        .addr_i      (q.addr),
        .dir_rd_i    (q.rd),
        .flip_i      (q.mods.flip_dir),
        .need_start_o(need_start),
        .addr_byte_o (addr_byte)
    );

    i2cseq_rx_out #(.DATA_W(8)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture_i (rx_capture),
        .data_i    (rsp_rdata_i),
        .rx_valid_o(rx_valid_o),
        .rx_data_o (rx_data_o)
    );

    always_comb begin
        d           = q;
        d.done_v    = 1'b0;
        msg_ready_o = 1'b0;
        tx_ready_o  = 1'b0;
        cmd_valid_o = 1'b0;
        op          = OP_START;
        cmd_wdata_o = '0;
        cmd_mack_o  = 1'b0;
        cmd_noack_o = 1'b0;
        rx_capture  = 1'b0;

        unique case (q.st)
            ST_IDLE: begin
                msg_ready_o = 1'b1;
                if (msg_valid_i) begin
                    d.addr = msg_addr_i;
                    d.rd   = msg_rd_i;
                    d.mods = msg_mod_t'(msg_mods_i);
                    d.len  = msg_len_i;
                    d.last = msg_last_i;
                    d.cnt  = '0;
                    d.st   = need_start ? ST_START : ST_DATA;
                end
            end

            ST_START: begin
                if (!q.wait_rsp) begin
                    cmd_valid_o = 1'b1;
                    op          = OP_START;
                    if (cmd_ready_i) d.wait_rsp = 1'b1;
                end else if (rsp_valid_i) begin
                    d.wait_rsp = 1'b0;
                    d.bus_open = 1'b1;
                    d.st       = q.mods.no_start ? ST_DATA : ST_ADDR;
                end
            end

            ST_ADDR: begin
                if (!q.wait_rsp) begin
                    cmd_valid_o = 1'b1;
                    op          = OP_WRITE;
                    cmd_wdata_o = addr_byte;
                    if (cmd_ready_i) d.wait_rsp = 1'b1;
                end else if (rsp_valid_i) begin
                    d.wait_rsp = 1'b0;
                    if (rsp_ack_i || q.mods.ign_nak) begin
                        d.st = ST_DATA;
                    end else begin
                        d.err       = 1'b1;
                        d.drain     = q.rd ? '0 : q.len;
                        d.drain_end = q.last;
                        d.st        = ST_STOP;
                    end
                end
            end

            ST_DATA: begin
                if (q.wait_rsp) begin
                    if (rsp_valid_i) begin
                        d.wait_rsp = 1'b0;
                        if (q.rd) begin
                            rx_capture = 1'b1;
                        end else if (!rsp_ack_i && !q.mods.ign_nak) begin
                            d.err       = 1'b1;
                            d.drain     = q.len - q.cnt;
                            d.drain_end = q.last;
                            d.st        = ST_STOP;
                        end
                    end
                end else if (q.cnt == q.len) begin
                    if (q.last || q.mods.force_stop) begin
                        d.st = ST_STOP;
                    end else begin
                        d.st  = ST_IDLE;
                        d.idx = q.idx + IDX_ONE;
                    end
                end else if (q.rd) begin
                    cmd_valid_o = 1'b1;
                    op          = OP_READ;
                    cmd_mack_o  = (q.cnt != q.len - LEN_ONE);
                    cmd_noack_o = q.mods.no_rd_ack;
                    if (cmd_ready_i) begin
                        d.wait_rsp = 1'b1;
                        d.cnt      = q.cnt + LEN_ONE;
                    end
                end else begin
                    cmd_valid_o = tx_valid_i;
                    op          = OP_WRITE;
                    cmd_wdata_o = tx_data_i;
                    tx_ready_o  = cmd_ready_i;
                    if (tx_valid_i && cmd_ready_i) begin
                        d.wait_rsp = 1'b1;
                        d.cnt      = q.cnt + LEN_ONE;
                    end
                end
            end

            ST_STOP: begin
                if (!q.wait_rsp) begin
                    cmd_valid_o = 1'b1;
                    op          = OP_STOP;
                    if (cmd_ready_i) d.wait_rsp = 1'b1;
                end else if (rsp_valid_i) begin
                    d.wait_rsp = 1'b0;
                    d.bus_open = 1'b0;
                    if (q.err) begin
                        d.st = ST_DRAIN;
                    end else if (q.last) begin
                        d.done_v   = 1'b1;
                        d.done_ok  = 1'b1;
                        d.done_idx = q.idx;
                        d.idx      = '0;
                        d.st       = ST_IDLE;
                    end else begin
                        d.idx = q.idx + IDX_ONE;
                        d.st  = ST_IDLE;
                    end
                end
            end

            ST_DRAIN: begin
                if (q.drain == '0) begin
                    if (q.drain_end) begin
                        d.done_v   = 1'b1;
                        d.done_ok  = 1'b0;
                        d.done_idx = q.idx;
                        d.idx      = '0;
                        d.err      = 1'b0;
                        d.st       = ST_IDLE;
                    end else begin
                        d.st = ST_FLUSH;
                    end
                end else begin
                    tx_ready_o = 1'b1;
                    if (tx_valid_i) d.drain = q.drain - LEN_ONE;
                end
            end

            ST_FLUSH: begin
                msg_ready_o = 1'b1;
                if (msg_valid_i) begin
                    d.drain     = msg_rd_i ? '0 : msg_len_i;
                    d.drain_end = msg_last_i;
                    d.st        = ST_DRAIN;
                end
            end

            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign cmd_op_o     = op;
    assign done_valid_o = q.done_v;
    assign done_ok_o    = q.done_ok;
    assign done_idx_o   = q.done_idx;

    p_one_outstanding_r13: assert property (@(posedge clk) disable iff (!rst_n)
        q.wait_rsp |-> !cmd_valid_o)
        else $error("p_one_outstanding_r13");

    p_nak_stops_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_DATA && q.wait_rsp && rsp_valid_i && !q.rd && !rsp_ack_i
         && !q.mods.ign_nak) |=> (q.st == ST_STOP))
        else $error("p_nak_stops_r5");

    p_flush_silent_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_DRAIN || q.st == ST_FLUSH) |-> !cmd_valid_o)
        else $error("p_flush_silent_r5");

    p_ign_continues_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((q.st == ST_ADDR || (q.st == ST_DATA && !q.rd)) && q.wait_rsp && rsp_valid_i
         && !rsp_ack_i && q.mods.ign_nak) |=> (q.st == ST_DATA))
        else $error("p_ign_continues_r6");

    p_done_source_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid_o |-> ($past(q.st) == ST_STOP || $past(q.st) == ST_DRAIN))
        else $error("p_done_source_r2");
endmodule

// File: tb/tb_i2c_xfer_sequencer.sv
module tb_i2c_xfer_sequencer;
    localparam int CLK_PERIOD = 10;
    localparam int LEN_W = 8;
    localparam int IDX_W = 4;
    localparam logic [4:0] MOD_IGN   = 5'h01;
    localparam logic [4:0] MOD_NOACK = 5'h02;
    localparam logic [4:0] MOD_NOST  = 5'h04;
    localparam logic [4:0] MOD_FLIP  = 5'h08;
    localparam logic [4:0] MOD_STOP  = 5'h10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic msg_valid = 1'b0, msg_ready;
    logic [6:0] msg_addr = '0;
    logic msg_rd = 1'b0;
    logic [LEN_W-1:0] msg_len = '0;
    logic [4:0] msg_mods = '0;
    logic msg_last = 1'b0;
    logic tx_valid = 1'b0, tx_ready;
    logic [7:0] tx_data = '0;
    logic rx_valid;
    logic [7:0] rx_data;
    logic cmd_valid, cmd_ready = 1'b1;
    logic [1:0] cmd_op;
    logic [7:0] cmd_wdata;
    logic cmd_mack, cmd_noack;
    logic rsp_valid = 1'b0, rsp_ack = 1'b0;
    logic [7:0] rsp_rdata = '0;
    logic done_valid, done_ok;
    logic [IDX_W-1:0] done_idx;

    i2c_xfer_sequencer #(.LEN_W(LEN_W), .IDX_W(IDX_W)) dut (
        .clk(clk), .rst_n(rst_n),
        .msg_valid_i(msg_valid), .msg_ready_o(msg_ready), .msg_addr_i(msg_addr),
        .msg_rd_i(msg_rd), .msg_len_i(msg_len), .msg_mods_i(msg_mods), .msg_last_i(msg_last),
        .tx_valid_i(tx_valid), .tx_ready_o(tx_ready), .tx_data_i(tx_data),
        .rx_valid_o(rx_valid), .rx_data_o(rx_data),
        .cmd_valid_o(cmd_valid), .cmd_ready_i(cmd_ready), .cmd_op_o(cmd_op),
        .cmd_wdata_o(cmd_wdata), .cmd_mack_o(cmd_mack), .cmd_noack_o(cmd_noack),
        .rsp_valid_i(rsp_valid), .rsp_ack_i(rsp_ack), .rsp_rdata_i(rsp_rdata),
        .done_valid_o(done_valid), .done_ok_o(done_ok), .done_idx_o(done_idx)
    );

    initial forever #(CLK_PERIOD/2) clk = ~clk;

    int n_checks = 0;
    int n_fail = 0;

    // message queue, payload, engine model and capture logs
    logic [6:0] m_addr [0:15];
    logic       m_rd   [0:15];
    logic [7:0] m_len  [0:15];
    logic [4:0] m_mods [0:15];
    logic       m_last [0:15];
    int n_msg = 0, msg_ptr = 0, q_n = 0;
    logic [7:0] tx_mem [0:31];
    int tx_n = 0, tx_ptr = 0;
    logic [11:0] cmd_log [0:63];
    logic [11:0] exp_log [0:63];
    int n_log = 0, exp_n = 0;
    logic [7:0] rx_log [0:15];
    int n_rx = 0;
    int done_cnt = 0;
    logic last_ok = 1'b0;
    logic [IDX_W-1:0] last_idx = '0;
    int nak_at = -1, wr_cnt = 0, rd_cnt = 0, viol = 0;

    task automatic chk(input string tag, input string what, input logic [31:0] act,
                       input logic [31:0] expv);
        n_checks++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
        end
    endtask

    // Engine, stream and monitor model: one process, acting at the falling edge.
    initial begin
        logic hs_msg, hs_tx, hs_cmd, busy, p_ack;
        logic [1:0] p_op;
        logic [7:0] p_rd;
        int lat;
        hs_msg = 0; hs_tx = 0; hs_cmd = 0; busy = 0; lat = 0;
        p_ack = 1; p_op = 0; p_rd = 0;
        forever begin
            @(negedge clk);
            if (hs_msg) msg_ptr++;
            if (hs_tx) tx_ptr++;
            rsp_valid = 1'b0;
            if (hs_cmd) begin
                busy = 1; lat = 2;
            end else if (busy) begin
                lat--;
                if (lat == 0) begin
                    busy = 0;
                    rsp_valid = 1'b1;
                    rsp_ack = p_ack;
                    rsp_rdata = p_rd;
                end
            end
            cmd_ready = !busy;
            msg_valid = (msg_ptr < n_msg);
            if (msg_ptr < 16) begin
                msg_addr = m_addr[msg_ptr]; msg_rd = m_rd[msg_ptr]; msg_len = m_len[msg_ptr];
                msg_mods = m_mods[msg_ptr]; msg_last = m_last[msg_ptr];
            end
            tx_valid = (tx_ptr < tx_n);
            tx_data = (tx_ptr < 32) ? tx_mem[tx_ptr] : 8'h00;
            #1;
            hs_msg = msg_valid && msg_ready;
            hs_tx  = tx_valid && tx_ready;
            hs_cmd = cmd_valid && cmd_ready;
            if (cmd_valid && busy) viol++;
            if (hs_cmd) begin
                p_op = cmd_op;
                p_ack = 1'b1;
                if (cmd_op == 2'd2) begin
                    p_ack = (wr_cnt != nak_at);
                    wr_cnt++;
                end
                if (cmd_op == 2'd3) begin
                    p_rd = 8'hC0 + 8'(rd_cnt);
                    rd_cnt++;
                end
                if (n_log < 64) begin
                    if (cmd_op == 2'd2)      cmd_log[n_log] = {2'd2, 2'b00, cmd_wdata};
                    else if (cmd_op == 2'd3) cmd_log[n_log] = {2'd3, cmd_noack, cmd_mack, 8'h00};
                    else                     cmd_log[n_log] = {cmd_op, 10'h000};
                end
                n_log++;
            end
            if (rx_valid) begin
                if (n_rx < 16) rx_log[n_rx] = rx_data;
                n_rx++;
            end
            if (done_valid) begin
                last_ok = done_ok; last_idx = done_idx; done_cnt++;
            end
        end
    end

    function automatic logic [11:0] e_start(); return {2'd0, 10'h000}; endfunction
    function automatic logic [11:0] e_stop();  return {2'd1, 10'h000}; endfunction
    function automatic logic [11:0] e_wr(input logic [7:0] b); return {2'd2, 2'b00, b}; endfunction
    function automatic logic [11:0] e_rd(input logic mack, input logic skip);
        return {2'd3, skip, mack, 8'h00};
    endfunction

    task automatic clear();
        n_msg = 0; msg_ptr = 0; q_n = 0; tx_n = 0; tx_ptr = 0;
        n_log = 0; exp_n = 0; n_rx = 0; wr_cnt = 0; rd_cnt = 0; nak_at = -1;
    endtask
    task automatic add_msg(input logic [6:0] a, input logic rd, input logic [7:0] len,
                           input logic [4:0] mods, input logic last);
        m_addr[q_n] = a; m_rd[q_n] = rd; m_len[q_n] = len; m_mods[q_n] = mods; m_last[q_n] = last;
        q_n++;
    endtask
    task automatic add_tx(input logic [7:0] b); tx_mem[tx_n] = b; tx_n++; endtask
    task automatic ex(input logic [11:0] e); exp_log[exp_n] = e; exp_n++; endtask

    task automatic go();
        int start_done;
        start_done = done_cnt;
        n_msg = q_n;
        while (done_cnt == start_done) @(posedge clk);
        repeat (3) @(posedge clk);
    endtask

    task automatic check_seq(input string tag);
        chk(tag, "primitive count", n_log, exp_n);
        for (int i = 0; i < exp_n && i < n_log; i++)
            chk(tag, $sformatf("primitive %0d", i), cmd_log[i], exp_log[i]);
    endtask
    task automatic check_done(input string tag, input logic ok, input int idx);
        chk(tag, "done_ok", last_ok, ok);
        chk(tag, "done_idx", last_idx, idx);
    endtask

    task automatic t_reset();
        @(negedge clk); #2;
        chk("R12", "msg_ready", msg_ready, 1);
        chk("R12", "cmd_valid", cmd_valid, 0);
        chk("R12", "rx_valid", rx_valid, 0);
        chk("R12", "done_valid", done_valid, 0);
    endtask

    task automatic t_write();
        clear();
        add_msg(7'h50, 0, 2, 0, 1); add_tx(8'h11); add_tx(8'h22);
        ex(e_start()); ex(e_wr(8'hA0)); ex(e_wr(8'h11)); ex(e_wr(8'h22)); ex(e_stop());
        go();
        check_seq("R2"); check_done("R2", 1, 0);
        chk("R2", "payload consumed", tx_ptr, 2);
    endtask

    task automatic t_read();
        clear();
        add_msg(7'h21, 1, 3, 0, 1);
        ex(e_start()); ex(e_wr(8'h43)); ex(e_rd(1, 0)); ex(e_rd(1, 0)); ex(e_rd(0, 0)); ex(e_stop());
        go();
        check_seq("R3"); check_done("R3", 1, 0);
        chk("R3", "rx count", n_rx, 3);
        for (int i = 0; i < 3; i++) chk("R3", $sformatf("rx byte %0d", i), rx_log[i], 8'hC0 + i);
    endtask

    task automatic t_combined();
        clear();
        add_msg(7'h10, 0, 1, 0, 0); add_msg(7'h11, 1, 1, 0, 1); add_tx(8'h5A);
        ex(e_start()); ex(e_wr(8'h20)); ex(e_wr(8'h5A));
        ex(e_start()); ex(e_wr(8'h23)); ex(e_rd(0, 0)); ex(e_stop());
        go();
        check_seq("R4"); check_done("R4", 1, 1);
        chk("R4", "rx byte", rx_log[0], 8'hC0);
    endtask

    task automatic t_nak_last_byte();
        // NAK on the final byte of a non-final message.
        clear();
        add_msg(7'h30, 0, 2, 0, 0); add_msg(7'h31, 0, 2, 0, 1);
        add_tx(8'h01); add_tx(8'h02); add_tx(8'h03); add_tx(8'h04);
        nak_at = 2;
        ex(e_start()); ex(e_wr(8'h60)); ex(e_wr(8'h01)); ex(e_wr(8'h02)); ex(e_stop());
        go();
        check_seq("R5"); check_done("R5", 0, 0);
        chk("R5", "payload consumed incl. dropped", tx_ptr, 4);
        chk("R5", "messages taken", msg_ptr, 2);
    endtask

    task automatic t_nak_addr();
        clear();
        add_msg(7'h30, 0, 1, 0, 0); add_msg(7'h31, 0, 2, 0, 1);
        add_tx(8'h0A); add_tx(8'h0B); add_tx(8'h0C);
        nak_at = 2;
        ex(e_start()); ex(e_wr(8'h60)); ex(e_wr(8'h0A)); ex(e_start()); ex(e_wr(8'h62)); ex(e_stop());
        go();
        check_seq("R5"); check_done("R5", 0, 1);
        chk("R5", "payload drained", tx_ptr, 3);
    endtask

    task automatic t_ignore_nak();
        clear();
        add_msg(7'h30, 0, 2, MOD_IGN, 0); add_msg(7'h31, 0, 1, 0, 1);
        add_tx(8'h01); add_tx(8'h02); add_tx(8'h03);
        nak_at = 2;
        ex(e_start()); ex(e_wr(8'h60)); ex(e_wr(8'h01)); ex(e_wr(8'h02));
        ex(e_start()); ex(e_wr(8'h62)); ex(e_wr(8'h03)); ex(e_stop());
        go();
        check_seq("R6"); check_done("R6", 1, 1);
    endtask

    task automatic t_no_rd_ack();
        clear();
        add_msg(7'h2A, 1, 2, MOD_NOACK, 1);
        ex(e_start()); ex(e_wr(8'h55)); ex(e_rd(1, 1)); ex(e_rd(0, 1)); ex(e_stop());
        go();
        check_seq("R7"); check_done("R7", 1, 0);
    endtask

    task automatic t_no_start_cont();
        clear();
        add_msg(7'h40, 0, 1, 0, 0); add_msg(7'h41, 0, 2, MOD_NOST, 1);
        add_tx(8'hD0); add_tx(8'hD1); add_tx(8'hD2);
        ex(e_start()); ex(e_wr(8'h80)); ex(e_wr(8'hD0)); ex(e_wr(8'hD1)); ex(e_wr(8'hD2)); ex(e_stop());
        go();
        check_seq("R8"); check_done("R8", 1, 1);
    endtask

    task automatic t_no_start_first();
        clear();
        add_msg(7'h44, 1, 1, MOD_NOST, 1);
        ex(e_start()); ex(e_rd(0, 0)); ex(e_stop());
        go();
        check_seq("R9");
        chk("R9", "rx count", n_rx, 1);
    endtask

    task automatic t_flip();
        clear();
        add_msg(7'h55, 0, 1, MOD_FLIP, 1); add_tx(8'h77);
        ex(e_start()); ex(e_wr(8'hAB)); ex(e_wr(8'h77)); ex(e_stop());
        go();
        check_seq("R1");
        chk("R1", "payload still written", tx_ptr, 1);
    endtask

    task automatic t_force_stop();
        clear();
        add_msg(7'h12, 0, 1, MOD_STOP, 0); add_msg(7'h13, 0, 1, 0, 1);
        add_tx(8'hE1); add_tx(8'hE2);
        ex(e_start()); ex(e_wr(8'h24)); ex(e_wr(8'hE1)); ex(e_stop());
        ex(e_start()); ex(e_wr(8'h26)); ex(e_wr(8'hE2)); ex(e_stop());
        go();
        check_seq("R10"); check_done("R10", 1, 1);
    endtask

    task automatic t_zero_len();
        clear();
        add_msg(7'h12, 0, 0, 0, 0); add_msg(7'h13, 1, 0, 0, 1);
        ex(e_start()); ex(e_wr(8'h24)); ex(e_start()); ex(e_wr(8'h27)); ex(e_stop());
        go();
        check_seq("R11"); check_done("R11", 1, 1);
        chk("R11", "no rx bytes", n_rx, 0);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        t_reset();
        @(posedge clk);
        rst_n = 1'b1;
        repeat (2) @(posedge clk);
        t_write();
        t_read();
        t_combined();
        t_nak_last_byte();
        t_nak_addr();
        t_ignore_nak();
        t_no_rd_ack();
        t_no_start_cont();
        t_no_start_first();
        t_flip();
        t_force_stop();
        t_zero_len();
        chk("R13", "primitive offered while one outstanding", viol, 0);
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule